// File: doc/BRIEF.md
# Transactional Access Tracker

This block keeps the speculative-access bookkeeping for a small, direct-mapped local data cache that runs in transactional mode. It does not hold cache data. For each line it holds a tag, a valid flag and a modified flag. For each word it holds a read flag and a renamed flag. Local loads and stores marked as speculative update these flags. Addresses that other processors broadcast while they commit are compared against the read flags. A match means the local transaction consumed a value that another processor has now overwritten, and the block raises a violation.

The processor's sequencer drives the two remaining operations. A commit pulse makes the block walk its line array. It emits one packet beat per modified line, carrying the line address and the mask of words written locally. The block then clears all tracking state, so every processor sees the whole write set of a transaction as one ordered burst. An abort pulse discards the transaction in one cycle. It drops every flag, invalidates each line that holds speculative writes, and clears the violation.

Top module: `txn_track_bits`

## Requirements
- R1: After reset, `viol_o`, `busy_o`, `pkt_valid`, `done_o` and `rsp_valid` are low and no line is valid, so any lookup returns `rsp_hit` = 0.
- R2: A word address splits into word offset (lowest log2(WORDS) bits), line index (next log2(LINES) bits) and tag (remaining upper bits). `rsp_valid` follows `req_valid` by one cycle. `rsp_hit` reports whether the indexed line was valid with a matching tag before that access.
- R3: A speculative load sets the read flag of its own word only. A snoop to another word of the same line raises no violation, while a snoop to the loaded word does.
- R4: A snoop whose tag, index and word match a set read flag raises `viol_o` on the next cycle. `viol_o` then stays high until `abort_i` is pulsed.
- R5: A speculative store sets the line's modified flag and the word's renamed flag, but not its read flag. A snoop to a word that was only stored raises no violation.
- R6: A speculative load of a word whose renamed flag is set leaves that word's read flag clear.
- R7: When a snoop and a speculative load hit the same word in the same cycle, the snoop is judged against the flags from before that cycle. That cycle raises no violation, and a later snoop of the word does.
- R8: A non-speculative access changes no flag and allocates no line.
- R9: A speculative access to an index whose line holds tracked state for a different tag raises `viol_o` and leaves the resident line in place.
- R10: A commit pulse sets `busy_o` on the next cycle. Starting one cycle later, the block emits one beat per cycle for each modified line in ascending index order. Each beat carries `pkt_addr` = {tag, index} and `pkt_mask` = the line's renamed flags, and `pkt_last` marks the final beat. `done_o` pulses together with the final beat, or alone one cycle after `busy_o` rises when no line is modified.
- R11: After a commit, all flags are clear and committed lines stay valid. A snoop to a previously read word raises no violation, and a second commit emits no beats.
- R12: An abort clears `viol_o` and all flags, invalidates lines with the modified flag set (later lookups miss), and keeps unmodified lines valid (later lookups hit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Local access present |
| req_store | input | 1 | Access is a store (else load) |
| req_spec | input | 1 | Access belongs to the running transaction |
| req_addr | input | ADDR_W | Word address of the access |
| snp_valid | input | 1 | Remote commit write present |
| snp_addr | input | ADDR_W | Word address written by the remote commit |
| commit_i | input | 1 | Start the commit walk |
| abort_i | input | 1 | Discard the transaction and acknowledge the violation |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Line was present with matching tag |
| viol_o | output | 1 | Sticky transaction violation |
| busy_o | output | 1 | Commit walk in progress |
| pkt_valid | output | 1 | Commit beat valid |
| pkt_addr | output | ADDR_W-log2(WORDS) | Line address of the beat |
| pkt_mask | output | WORDS | Words written in that line |
| pkt_last | output | 1 | Final beat of the packet |
| done_o | output | 1 | Commit walk finished |

## Verification
A read flag that is lost appears as a missing `viol_o` one cycle after the matching snoop. A spurious read flag, such as one set by a store or by a renamed load, appears as a false `viol_o` within the same delay. Modified or renamed state that is wrong appears in the commit packet: a missing or extra beat, a wrong mask, or a wrong order. The scoreboard catches these as the beats arrive. Faulty invalidation or clearing after an abort or a commit shows on the next lookup, through `rsp_hit`, or on the next snoop or commit.

// File: rtl/ttb_pkg.sv
package ttb_pkg;
  typedef enum logic {
    WALK_IDLE = 1'b0,
    WALK_RUN  = 1'b1
  } walk_state_e;
endpackage

// File: rtl/ttb_pick_low.sv
module ttb_pick_low #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
  assign any = |vec;
endmodule

// File: rtl/ttb_lines.sv
module ttb_lines #(
  parameter int LINES = 8,
  parameter int WORDS = 4,
  parameter int TAG_W = 7,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_en,
  input  logic             acc_store,
  input  logic             acc_alloc,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic [TAG_W-1:0] acc_tag,
  input  logic [OFF_W-1:0] acc_word,
  input  logic             clr_all,
  input  logic             abort_i,
  output logic [LINES-1:0] vld_q,
  output logic [LINES-1:0] mod_q,
  output logic [TAG_W-1:0] tag_q [LINES],
  output logic [WORDS-1:0] rd_q  [LINES],
  output logic [WORDS-1:0] rn_q  [LINES]
);
  logic [WORDS-1:0] word_oh;
  assign word_oh = WORDS'(1) << acc_word;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic sel;
    assign sel = acc_en && (acc_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q[i] <= 1'b0;
        mod_q[i] <= 1'b0;
        tag_q[i] <= '0;
        rd_q[i]  <= '0;
        rn_q[i]  <= '0;
      end else if (abort_i) begin
        if (mod_q[i]) vld_q[i] <= 1'b0;
        mod_q[i] <= 1'b0;
        rd_q[i]  <= '0;
        rn_q[i]  <= '0;
      end else if (clr_all) begin
        mod_q[i] <= 1'b0;
        rd_q[i]  <= '0;
        rn_q[i]  <= '0;
      end else if (sel) begin
        if (acc_alloc) begin
          vld_q[i] <= 1'b1;
          tag_q[i] <= acc_tag;
          mod_q[i] <= acc_store;
          rd_q[i]  <= acc_store ? '0 : word_oh;
          rn_q[i]  <= acc_store ? word_oh : '0;
        end else if (acc_store) begin
          mod_q[i] <= 1'b1;
          rn_q[i]  <= rn_q[i] | word_oh;
        end else if ((rn_q[i] & word_oh) == '0) begin
          rd_q[i]  <= rd_q[i] | word_oh;
        end
      end
    end
  end

  // R12: a line carrying speculative writes is always a valid line
  p_mod_valid_r12: assert property (@(posedge clk) disable iff (rst)
    (mod_q & ~vld_q) == '0);
  // R12: abort leaves no modified line behind
  p_abort_mod_r12: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> (mod_q == '0));
endmodule

// File: rtl/ttb_commit_walk.sv
module ttb_commit_walk
  import ttb_pkg::*;
#(
  parameter int LINES = 8,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             kill,
  input  logic [LINES-1:0] mod_vec,
  output logic             busy_o,
  output logic [IDX_W-1:0] sel_idx,
  output logic             emit,
  output logic             last,
  output logic             fin
);
  walk_state_e      st_q;
  logic [LINES-1:0] pend_q;
  logic             any;

  ttb_pick_low #(.N(LINES), .IW(IDX_W)) u_pick (
    .vec (pend_q),
    .idx (sel_idx),
    .any (any)
  );

  assign busy_o = (st_q == WALK_RUN);
  assign emit   = busy_o && any;
  assign last   = busy_o && ($countones(pend_q) == 1);
  assign fin    = busy_o && (!any || last);

  always_ff @(posedge clk) begin
    if (rst || kill) begin
      st_q   <= WALK_IDLE;
      pend_q <= '0;
    end else if (st_q == WALK_IDLE) begin
      if (start) begin
        st_q   <= WALK_RUN;
        pend_q <= mod_vec;
      end
    end else begin
      if (any) pend_q <= pend_q & ~(LINES'(1) << sel_idx);
      if (fin) st_q <= WALK_IDLE;
    end
  end

  // R10: each walk step retires exactly one pending line
  p_pend_step_r10: assert property (@(posedge clk) disable iff (rst)
    (busy_o && any && !kill) |=> ($countones(pend_q) + 1 == $countones($past(pend_q))));
endmodule

// File: rtl/txn_track_bits.sv
module txn_track_bits #(
  parameter int ADDR_W = 12,
  parameter int LINES  = 8,
  parameter int WORDS  = 4,
  localparam int OFF_W   = $clog2(WORDS),
  localparam int IDX_W   = $clog2(LINES),
  localparam int TAG_W   = ADDR_W - OFF_W - IDX_W,
  localparam int LADDR_W = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_store,
  input  logic               req_spec,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               snp_valid,
  input  logic [ADDR_W-1:0]  snp_addr,
  input  logic               commit_i,
  input  logic               abort_i,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic               viol_o,
  output logic               busy_o,
  output logic               pkt_valid,
  output logic [LADDR_W-1:0] pkt_addr,
  output logic [WORDS-1:0]   pkt_mask,
  output logic               pkt_last,
  output logic               done_o
);
  logic [LINES-1:0] vld_q, mod_q;
  logic [TAG_W-1:0] tag_q [LINES];
  logic [WORDS-1:0] rd_q  [LINES];
  logic [WORDS-1:0] rn_q  [LINES];

  // request decode
  logic [OFF_W-1:0] r_word;
  logic [IDX_W-1:0] r_idx;
  logic [TAG_W-1:0] r_tag;
  assign r_word = req_addr[OFF_W-1:0];
  assign r_idx  = req_addr[OFF_W +: IDX_W];
  assign r_tag  = req_addr[ADDR_W-1 -: TAG_W];

  // snoop decode
  logic [OFF_W-1:0] s_word;
  logic [IDX_W-1:0] s_idx;
  logic [TAG_W-1:0] s_tag;
  assign s_word = snp_addr[OFF_W-1:0];
  assign s_idx  = snp_addr[OFF_W +: IDX_W];
  assign s_tag  = snp_addr[ADDR_W-1 -: TAG_W];

  logic walk_busy, walk_emit, walk_last, walk_fin;
  logic [IDX_W-1:0] walk_idx;

  logic r_hit, r_tracked, spec_go, conflict, acc_en, s_hit;
  assign r_hit     = vld_q[r_idx] && (tag_q[r_idx] == r_tag);
  assign r_tracked = mod_q[r_idx] || (rd_q[r_idx] != '0) || (rn_q[r_idx] != '0);
  assign spec_go   = req_valid && req_spec && !walk_busy && !abort_i && !commit_i;
  assign conflict  = spec_go && vld_q[r_idx] && !r_hit && r_tracked;
  assign acc_en    = spec_go && !conflict;
  assign s_hit     = snp_valid && vld_q[s_idx] && (tag_q[s_idx] == s_tag)
                     && rd_q[s_idx][s_word];

  ttb_lines #(.LINES(LINES), .WORDS(WORDS), .TAG_W(TAG_W)) u_lines (
    .clk       (clk),
    .rst       (rst),
    .acc_en    (acc_en),
    .acc_store (req_store),
    .acc_alloc (!r_hit),
    .acc_idx   (r_idx),
    .acc_tag   (r_tag),
    .acc_word  (r_word),
    .clr_all   (walk_fin),
    .abort_i   (abort_i),
    .vld_q     (vld_q),
    .mod_q     (mod_q),
    .tag_q     (tag_q),
    .rd_q      (rd_q),
    .rn_q      (rn_q)
  );

  ttb_commit_walk #(.LINES(LINES)) u_walk (
    .clk     (clk),
    .rst     (rst),
    .start   (commit_i && !abort_i),
    .kill    (abort_i),
    .mod_vec (mod_q),
    .busy_o  (walk_busy),
    .sel_idx (walk_idx),
    .emit    (walk_emit),
    .last    (walk_last),
    .fin     (walk_fin)
  );
  assign busy_o = walk_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      viol_o    <= 1'b0;
      pkt_valid <= 1'b0;
      pkt_addr  <= '0;
      pkt_mask  <= '0;
      pkt_last  <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && r_hit;
      if (abort_i)                viol_o <= 1'b0;
      else if (s_hit || conflict) viol_o <= 1'b1;
      pkt_valid <= walk_emit && !abort_i;
      pkt_addr  <= {tag_q[walk_idx], walk_idx};
      pkt_mask  <= rn_q[walk_idx];
      pkt_last  <= walk_last && !abort_i;
      done_o    <= walk_fin && !abort_i;
    end
  end

  // R4: violation holds until acknowledged
  p_viol_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (viol_o && !abort_i) |=> viol_o);
  // R12: abort drops the violation
  p_abort_viol_r12: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> !viol_o);
  // R2: every request gets a response one cycle later
  p_rsp_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  // R10: final beat is followed by a quiet cycle
  p_last_gap_r10: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && pkt_last) |=> !pkt_valid);
  // R10: done never accompanies a non-final beat
  p_done_last_r10: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && !pkt_last) |-> !done_o);
endmodule

// File: tb/sim_txn_track_bits.sv
module sim_txn_track_bits;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12, LINES = 8, WORDS = 4;
  localparam int LADDR_W = ADDR_W - 2;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_store = 0, req_spec = 0, snp_valid = 0, commit_i = 0, abort_i = 0;
  logic [ADDR_W-1:0] req_addr = '0, snp_addr = '0;
  logic rsp_valid, rsp_hit, viol_o, busy_o, pkt_valid, pkt_last, done_o;
  logic [LADDR_W-1:0] pkt_addr;
  logic [WORDS-1:0] pkt_mask;

  always #(CLK_PERIOD/2) clk = ~clk;

  txn_track_bits #(.ADDR_W(ADDR_W), .LINES(LINES), .WORDS(WORDS)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store), .req_spec(req_spec),
    .req_addr(req_addr), .snp_valid(snp_valid), .snp_addr(snp_addr), .commit_i(commit_i),
    .abort_i(abort_i), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .viol_o(viol_o),
    .busy_o(busy_o), .pkt_valid(pkt_valid), .pkt_addr(pkt_addr), .pkt_mask(pkt_mask),
    .pkt_last(pkt_last), .done_o(done_o));

  int checks = 0, errors = 0, beats_got = 0;
  bit seen_done = 0;
  logic [LADDR_W+WORDS:0] exp_q [$];

  function automatic logic [ADDR_W-1:0] wa(int tag, int idx, int w);
    return {7'(tag), 3'(idx), 2'(w)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input bit rv, input bit rs, input bit rp, input logic [ADDR_W-1:0] ra,
                     input bit sv, input logic [ADDR_W-1:0] sa, input bit cm, input bit ab);
    req_valid = rv; req_store = rs; req_spec = rp; req_addr = ra;
    snp_valid = sv; snp_addr = sa; commit_i = cm; abort_i = ab;
    @(negedge clk);
    req_valid = 0; req_store = 0; req_spec = 0; snp_valid = 0; commit_i = 0; abort_i = 0;
  endtask

  task automatic lookup(input logic [ADDR_W-1:0] a, input bit exp, input string req);
    cyc(1, 0, 0, a, 0, '0, 0, 0);
    chk(rsp_valid === 1'b1 && rsp_hit === exp, req, int'(rsp_hit), int'(exp));
  endtask

  task automatic snoop(input logic [ADDR_W-1:0] a, input bit exp, input string req);
    cyc(0, 0, 0, '0, 1, a, 0, 0);
    chk(viol_o === exp, req, int'(viol_o), int'(exp));
  endtask

  task automatic push_beat(input int tag, input int idx, input int mask, input bit lst);
    exp_q.push_back({7'(tag), 3'(idx), 4'(mask), lst});
  endtask

  task automatic do_commit(input int nexp, input string req);
    beats_got = 0; seen_done = 0;
    cyc(0, 0, 0, '0, 0, '0, 1, 0);
    chk(busy_o === 1'b1, req, int'(busy_o), 1);
    for (int k = 0; k < 30 && !seen_done; k++) @(posedge clk);
    @(negedge clk);
    chk(seen_done == 1'b1, req, int'(seen_done), 1);
    chk(beats_got == nexp, req, beats_got, nexp);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    chk(busy_o === 1'b0, req, int'(busy_o), 0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (pkt_valid === 1'b1) begin
        beats_got++;
        if (exp_q.size() == 0) begin
          chk(0, "R10 unexpected beat", int'(pkt_addr), -1);
        end else begin
          logic [LADDR_W+WORDS:0] e;
          e = exp_q.pop_front();
          chk({pkt_addr, pkt_mask, pkt_last} === e, "R10 beat content",
              int'({pkt_addr, pkt_mask, pkt_last}), int'(e));
          chk(done_o === pkt_last, "R10 done with final beat", int'(done_o), int'(pkt_last));
        end
      end
      if (done_o === 1'b1) seen_done = 1;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(viol_o === 0 && busy_o === 0 && pkt_valid === 0 && done_o === 0 && rsp_valid === 0,
        "R1 outputs low", int'({viol_o, busy_o, pkt_valid, done_o, rsp_valid}), 0);
    lookup(wa(5, 1, 0), 0, "R1 no valid line");
    // R8 non-speculative accesses leave no trace
    cyc(1, 0, 0, wa(5, 1, 0), 0, '0, 0, 0);
    cyc(1, 1, 0, wa(5, 1, 1), 0, '0, 0, 0);
    lookup(wa(5, 1, 0), 0, "R8 no allocation");
    // R2 / R3 speculative load allocates and marks its word
    cyc(1, 0, 1, wa(5, 1, 0), 0, '0, 0, 0);
    chk(rsp_hit === 0, "R2 first access misses", int'(rsp_hit), 0);
    lookup(wa(5, 1, 2), 1, "R2 same line hits");
    lookup(wa(6, 1, 0), 0, "R2 other tag misses");
    snoop(wa(5, 1, 2), 0, "R3 other word no violation");
    // R4 sticky violation
    snoop(wa(5, 1, 0), 1, "R4 read word violation");
    repeat (3) @(negedge clk);
    chk(viol_o === 1, "R4 violation held", int'(viol_o), 1);
    cyc(0, 0, 0, '0, 0, '0, 0, 1);
    chk(viol_o === 0, "R12 abort clears violation", int'(viol_o), 0);
    lookup(wa(5, 1, 0), 1, "R12 read-only line kept");
    snoop(wa(5, 1, 0), 0, "R12 read flags cleared");
    // R5 / R6 store and renamed load
    cyc(1, 1, 1, wa(3, 2, 1), 0, '0, 0, 0);
    snoop(wa(3, 2, 1), 0, "R5 stored word no violation");
    cyc(1, 0, 1, wa(3, 2, 1), 0, '0, 0, 0);
    snoop(wa(3, 2, 1), 0, "R6 renamed load no read flag");
    cyc(1, 0, 1, wa(3, 2, 3), 0, '0, 0, 0);
    snoop(wa(3, 2, 3), 1, "R3 load in modified line");
    cyc(0, 0, 0, '0, 0, '0, 0, 1);
    lookup(wa(3, 2, 0), 0, "R12 modified line invalidated");
    do_commit(0, "R12 nothing to commit after abort");
    // R7 same-cycle snoop and load
    cyc(1, 0, 1, wa(4, 3, 1), 1, wa(4, 3, 1), 0, 0);
    chk(viol_o === 0, "R7 same cycle uses old flags", int'(viol_o), 0);
    snoop(wa(4, 3, 1), 1, "R7 later snoop violates");
    cyc(0, 0, 0, '0, 0, '0, 0, 1);
    // R9 conflicting tag on tracked line
    cyc(1, 0, 1, wa(4, 3, 1), 0, '0, 0, 0);
    cyc(1, 1, 1, wa(9, 3, 0), 0, '0, 0, 0);
    chk(viol_o === 1, "R9 conflict violation", int'(viol_o), 1);
    lookup(wa(4, 3, 0), 1, "R9 resident line kept");
    cyc(0, 0, 0, '0, 0, '0, 0, 1);
    // R10 commit packet
    cyc(1, 1, 1, wa(2, 5, 0), 0, '0, 0, 0);
    cyc(1, 1, 1, wa(2, 5, 3), 0, '0, 0, 0);
    cyc(1, 0, 1, wa(2, 4, 0), 0, '0, 0, 0);
    cyc(1, 1, 1, wa(7, 6, 1), 0, '0, 0, 0);
    cyc(1, 1, 1, wa(1, 0, 2), 0, '0, 0, 0);
    push_beat(1, 0, 4'b0100, 0);
    push_beat(2, 5, 4'b1001, 0);
    push_beat(7, 6, 4'b0010, 1);
    do_commit(3, "R10 commit walk");
    // R11 after commit
    lookup(wa(2, 5, 0), 1, "R11 committed line valid");
    snoop(wa(2, 4, 0), 0, "R11 read flags cleared");
    do_commit(0, "R11 second commit empty");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule